// File: doc/BRIEF.md
# Cyclic-Prefix Correlation Symbol Timing Estimator

This block finds the integer sample offset at which a multicarrier symbol starts in a received stream of real, signed samples. It exploits the fact that every symbol is preceded by a cyclic prefix: the prefix samples repeat the tail of the symbol body exactly one body length (2N samples) later. For every candidate offset D the block multiplies each sample with the sample 2N positions further on and adds up n such products, where n is the prefix length. The offset whose sum is largest is taken as the symbol start. Only the whole-sample part of the delay is produced; fractional timing is left to a separate loop.

A search starts with the first accepted sample after reset or after the previous result, and it spans one full symbol of 2N+n candidate offsets. This needs 4N+2n-1 accepted samples. The correlation is kept as a running sum. Each new product enters the sum and the product that falls out of the n-wide window leaves it. A 2N-deep sample line supplies the lagged operand. The control path is a four-state machine. FILL loads the lag line (2N samples) and moves to RAMP. RAMP fills the product window (n-1 products) and moves to SRCH. SRCH judges one candidate per accepted sample and moves to DONE after the last one. DONE presents the result for one cycle and moves back to FILL. With defaults (2N=16, n=8, 12-bit samples) a search uses 47 samples and judges 24 offsets.

Top module: `cp_timing_est`

## Requirements
- R1: A search accepts exactly 2*SYM_LEN + 2*CP_LEN - 1 samples (47 by default), counted from the first sample with `smp_valid_i` high after reset or after the done cycle.
- R2: Number the accepted samples x[0], x[1], ... from the start of the search. The metric is M(D) = sum over i=0..CP_LEN-1 of x[D+i]*x[D+i+SYM_LEN], for D = 0..SYM_LEN+CP_LEN-1. `offset_o` is the D with the largest M(D), including the boundary candidates D=0 and D=SYM_LEN+CP_LEN-1.
- R3: When several candidates share the largest metric, `offset_o` reports the smallest of them. An all-zero input gives offset 0.
- R4: `peak_o` equals the largest M(D) exactly, as a two's-complement value. It does not overflow even when every sample is full-scale -2048 (result CP_LEN*2^22 = 33554432 by default).
- R5: `done_o` is high for exactly one cycle. That cycle directly follows the clock edge that accepted the last sample of the search, and `done_o` is never high at any other time.
- R6: `offset_o` and `peak_o` take their new values at that same edge and hold them until the next search completes.
- R7: A cycle with `smp_valid_i` low has no effect on the search. Gaps between samples leave the result unchanged.
- R8: A sample presented during the done cycle is discarded. The next search starts with the next sample accepted after that cycle.
- R9: While `rst_ni` is low, `done_o`, `offset_o` and `peak_o` are 0. A partly completed search is abandoned, and the next search starts from the first sample after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| smp_valid_i | input | 1 | Qualifies `smp_i` in this cycle |
| smp_i | input | SAMP_W | Signed received sample |
| offset_o | output | $clog2(SYM_LEN+CP_LEN) | Estimated integer symbol offset D |
| peak_o | output | 2*SAMP_W+$clog2(CP_LEN)+1 | Signed correlation value at the chosen offset |
| done_o | output | 1 | One-cycle strobe marking a fresh result |

## Verification
The bench targets several corner cases, and each has a visible failure mode:
- **Peaks at the first and last candidate.** A design that drops the last candidate or skips the D=0 window would report a neighbouring offset.
- **Ties across a plateau.** A design that uses a greater-or-equal compare would report the latest of the tied offsets instead of the earliest.
- **Full-scale negative samples.** Undersized accumulation would wrap, and the peak would come out negative or truncated.
- **Bubbles in the valid stream.** A design that shifts or accumulates on invalid cycles would report shifted offsets.
- **Junk sample in the done cycle.** A design that consumes it would misalign the following search.
- **Reset in mid-search.** A design that keeps stale window contents would give a wrong first estimate after reset.

// File: rtl/cpc_pkg.sv
package cpc_pkg;

    typedef enum logic [1:0] {
        ST_FILL = 2'd0,
        ST_RAMP = 2'd1,
        ST_SRCH = 2'd2,
        ST_DONE = 2'd3
    } cpc_state_t;

    function automatic int prod_w(input int samp_w);
        return 2 * samp_w;
    endfunction

    function automatic int acc_w(input int samp_w, input int cp_len);
        return 2 * samp_w + $clog2(cp_len) + 1;
    endfunction

    function automatic int off_w(input int sym_len, input int cp_len);
        return $clog2(sym_len + cp_len);
    endfunction

endpackage

// File: rtl/cpc_lag_line.sv
module cpc_lag_line #(
    parameter int W     = 12,
    parameter int DEPTH = 16
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                shift_i,
    input  logic signed [W-1:0] din_i,
    output logic signed [W-1:0] lag_o
);
    logic signed [W-1:0] tap [DEPTH];

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int i = 0; i < DEPTH; i++) tap[i] <= '0;
        end else if (shift_i) begin
            tap[0] <= din_i;
            for (int i = 1; i < DEPTH; i++) tap[i] <= tap[i-1];
        end
    end

    // oldest entry: the sample taken DEPTH accepted samples ago
    assign lag_o = tap[DEPTH-1];
endmodule

// File: rtl/cpc_corr_window.sv
module cpc_corr_window #(
    parameter int W     = 12,
    parameter int WIN   = 8,
    parameter int PW    = 24,
    parameter int AW    = 28
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 clr_i,
    input  logic                 push_i,
    input  logic signed [W-1:0]  cur_i,
    input  logic signed [W-1:0]  lag_i,
    output logic signed [AW-1:0] sum_next_o
);
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] pline [WIN];
    logic signed [AW-1:0] sum_q;
    logic signed [AW-1:0] prod_x;
    logic signed [AW-1:0] leave_x;

    assign prod    = cur_i * lag_i;
    assign prod_x  = AW'(prod);
    assign leave_x = AW'(pline[WIN-1]);

    // running window: newest product in, oldest product out
    assign sum_next_o = sum_q + prod_x - leave_x;

    always_ff @(posedge clk_i) begin
        if (!rst_ni || clr_i) begin
            sum_q <= '0;
            for (int i = 0; i < WIN; i++) pline[i] <= '0;
        end else if (push_i) begin
            sum_q    <= sum_next_o;
            pline[0] <= prod;
            for (int i = 1; i < WIN; i++) pline[i] <= pline[i-1];
        end
    end
endmodule

// File: rtl/cpc_peak_pick.sv
module cpc_peak_pick #(
    parameter int AW = 28,
    parameter int OW = 5
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 eval_i,
    input  logic                 first_i,
    input  logic                 last_i,
    input  logic signed [AW-1:0] metric_i,
    input  logic [OW-1:0]        cand_i,
    output logic [OW-1:0]        off_o,
    output logic signed [AW-1:0] peak_o
);
    logic signed [AW-1:0] best_m;
    logic [OW-1:0]        best_d;
    logic                 win;
    logic signed [AW-1:0] new_m;
    logic [OW-1:0]        new_d;

    // strict compare keeps the earliest offset among equals
    assign win   = first_i || (metric_i > best_m);
    assign new_m = win ? metric_i : best_m;
    assign new_d = win ? cand_i   : best_d;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            best_m <= '0;
            best_d <= '0;
            off_o  <= '0;
            peak_o <= '0;
        end else if (eval_i) begin
            best_m <= new_m;
            best_d <= new_d;
            if (last_i) begin
                off_o  <= new_d;
                peak_o <= new_m;
            end
        end
    end
endmodule

// File: rtl/cpc_ctrl.sv
module cpc_ctrl
    import cpc_pkg::*;
#(
    parameter int SYM_LEN = 16,
    parameter int CP_LEN  = 8,
    parameter int OW      = 5
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          valid_i,
    output logic          shift_o,
    output logic          push_o,
    output logic          eval_o,
    output logic          first_o,
    output logic          last_o,
    output logic          clr_o,
    output logic          done_o,
    output logic [OW-1:0] cand_o
);
    localparam int NCAND     = SYM_LEN + CP_LEN;
    localparam int CW        = $clog2(NCAND + 1);
    localparam int RAMP_LAST = (CP_LEN > 1) ? CP_LEN - 2 : 0;

    cpc_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          fill_end, ramp_end, srch_end;

    assign fill_end = (cnt_q == CW'(SYM_LEN - 1));
    assign ramp_end = (cnt_q == CW'(RAMP_LAST));
    assign srch_end = (cnt_q == CW'(NCAND - 1));

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= ST_FILL;
        else         state_q <= state_d;
    end

    // phase counter
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            unique case (state_q)
                ST_FILL: if (valid_i) cnt_q <= fill_end ? '0 : cnt_q + 1'b1;
                ST_RAMP: if (valid_i) cnt_q <= ramp_end ? '0 : cnt_q + 1'b1;
                ST_SRCH: if (valid_i) cnt_q <= srch_end ? '0 : cnt_q + 1'b1;
                ST_DONE: cnt_q <= '0;
                default: cnt_q <= '0;
            endcase
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL: if (valid_i && fill_end)
                         state_d = (CP_LEN > 1) ? ST_RAMP : ST_SRCH;
            ST_RAMP: if (valid_i && ramp_end) state_d = ST_SRCH;
            ST_SRCH: if (valid_i && srch_end) state_d = ST_DONE;
            ST_DONE: state_d = ST_FILL;
            default: state_d = ST_FILL;
        endcase
    end

    // outputs
    always_comb begin
        shift_o = 1'b0;
        push_o  = 1'b0;
        eval_o  = 1'b0;
        clr_o   = 1'b0;
        done_o  = 1'b0;
        unique case (state_q)
            ST_FILL: shift_o = valid_i;
            ST_RAMP: begin
                shift_o = valid_i;
                push_o  = valid_i;
            end
            ST_SRCH: begin
                shift_o = valid_i;
                push_o  = valid_i;
                eval_o  = valid_i;
            end
            ST_DONE: begin
                clr_o  = 1'b1;
                done_o = 1'b1;
            end
            default: clr_o = 1'b1;
        endcase
    end

    assign first_o = (cnt_q == '0);
    assign last_o  = srch_end;
    assign cand_o  = cnt_q[OW-1:0];
endmodule

// File: rtl/cp_timing_est.sv
module cp_timing_est
    import cpc_pkg::*;
#(
    parameter int SYM_LEN = 16,
    parameter int CP_LEN  = 8,
    parameter int SAMP_W  = 12
) (
    input  logic                                       clk_i,
    input  logic                                       rst_ni,
    input  logic                                       smp_valid_i,
    input  logic signed [SAMP_W-1:0]                   smp_i,
    output logic [off_w(SYM_LEN, CP_LEN)-1:0]          offset_o,
    output logic signed [acc_w(SAMP_W, CP_LEN)-1:0]    peak_o,
    output logic                                       done_o
);
    localparam int PW = prod_w(SAMP_W);
    localparam int AW = acc_w(SAMP_W, CP_LEN);
    localparam int OW = off_w(SYM_LEN, CP_LEN);

    logic                 shift, push, eval, first, last, clr;
    logic [OW-1:0]        cand;
    logic signed [SAMP_W-1:0] lag;
    logic signed [AW-1:0] metric;

    cpc_ctrl #(
        .SYM_LEN(SYM_LEN),
        .CP_LEN (CP_LEN),
        .OW     (OW)
    ) u_ctrl (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .valid_i(smp_valid_i),
        .shift_o(shift),
        .push_o (push),
        .eval_o (eval),
        .first_o(first),
        .last_o (last),
        .clr_o  (clr),
        .done_o (done_o),
        .cand_o (cand)
    );

    cpc_lag_line #(
        .W    (SAMP_W),
        .DEPTH(SYM_LEN)
    ) u_lag (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .shift_i(shift),
        .din_i  (smp_i),
        .lag_o  (lag)
    );

    cpc_corr_window #(
        .W  (SAMP_W),
        .WIN(CP_LEN),
        .PW (PW),
        .AW (AW)
    ) u_win (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clr_i     (clr),
        .push_i    (push),
        .cur_i     (smp_i),
        .lag_i     (lag),
        .sum_next_o(metric)
    );

    cpc_peak_pick #(
        .AW(AW),
        .OW(OW)
    ) u_pick (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .eval_i  (eval),
        .first_i (first),
        .last_i  (last),
        .metric_i(metric),
        .cand_i  (cand),
        .off_o   (offset_o),
        .peak_o  (peak_o)
    );
endmodule

// File: rtl/cp_timing_est_chk.sv
module cp_timing_est_chk
    import cpc_pkg::*;
#(
    parameter int SYM_LEN = 16,
    parameter int CP_LEN  = 8,
    parameter int SAMP_W  = 12
) (
    input logic                                    clk_i,
    input logic                                    rst_ni,
    input logic                                    smp_valid_i,
    input logic [off_w(SYM_LEN, CP_LEN)-1:0]       offset_o,
    input logic signed [acc_w(SAMP_W, CP_LEN)-1:0] peak_o,
    input logic                                    done_o
);
    localparam int AW    = acc_w(SAMP_W, CP_LEN);
    localparam int TOTAL = 2 * SYM_LEN + 2 * CP_LEN - 1;
    localparam int NCAND = SYM_LEN + CP_LEN;
    localparam logic signed [AW-1:0] PK_MAX =
        AW'(CP_LEN) <<< (2 * SAMP_W - 2);

    int unsigned taken;

    always_ff @(posedge clk_i) begin
        if (!rst_ni || done_o) taken <= 0;
        else if (smp_valid_i)  taken <= taken + 1;
    end

    // R1: a result appears only after a full search worth of samples
    a_r1_sample_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (taken == TOTAL));

    // R5: the strobe lasts one cycle
    a_r5_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R6: results move only together with the strobe
    a_r6_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> ($stable(offset_o) && $stable(peak_o)));

    // R2: reported offset lies inside the candidate range
    a_r2_offset_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (int'(offset_o) < NCAND));

    // R4: peak never exceeds the full-scale bound
    a_r4_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
        peak_o <= PK_MAX);
endmodule

bind cp_timing_est cp_timing_est_chk #(
    .SYM_LEN(SYM_LEN),
    .CP_LEN (CP_LEN),
    .SAMP_W (SAMP_W)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .smp_valid_i(smp_valid_i),
    .offset_o   (offset_o),
    .peak_o     (peak_o),
    .done_o     (done_o)
);

// File: tb/cp_timing_est_tb_top.sv
module cp_timing_est_tb_top;
    localparam int SYM   = 16;
    localparam int CP    = 8;
    localparam int SW    = 12;
    localparam int TOTAL = 2 * SYM + 2 * CP - 1;
    localparam int NC    = SYM + CP;
    localparam int AW    = 2 * SW + $clog2(CP) + 1;
    localparam int OW    = $clog2(NC);

    // vector table: true prefix position, body amplitude, seed, bubble gap, junk-in-done flag
    localparam int NVEC = 7;
    localparam int VEC [NVEC][5] = '{
        '{ 0,  900, 11, 0, 0},
        '{ 5, 1500, 23, 2, 0},
        '{12,  600, 37, 0, 1},
        '{23, 2000, 41, 1, 0},
        '{17,  300, 53, 0, 0},
        '{ 9, 1800, 67, 3, 0},
        '{ 1, 2047, 79, 0, 0}
    };

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 vld = 1'b0;
    logic signed [SW-1:0] smp = '0;
    logic [OW-1:0]        off;
    logic signed [AW-1:0] pk;
    logic                 done;

    int n_run  = 0;
    int n_fail = 0;

    logic signed [SW-1:0] seq [TOTAL];
    int    exp_d;
    longint exp_m;

    always #4 clk = ~clk;

    cp_timing_est #(
        .SYM_LEN(SYM),
        .CP_LEN (CP),
        .SAMP_W (SW)
    ) dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .smp_valid_i(vld),
        .smp_i      (smp),
        .offset_o   (off),
        .peak_o     (pk),
        .done_o     (done)
    );

    task automatic chk(input string req, input longint act, input longint expv);
        n_run++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic ref_model();
        for (int d = 0; d < NC; d++) begin
            longint m = 0;
            for (int i = 0; i < CP; i++)
                m += longint'(seq[d+i]) * longint'(seq[d+i+SYM]);
            if (d == 0 || m > exp_m) begin
                exp_m = m;
                exp_d = d;
            end
        end
    endtask

    task automatic build(input int dly, input int amp, input int seed);
        int unsigned lcg = seed;
        int b [SYM];
        for (int k = 0; k < TOTAL; k++) begin
            lcg = lcg * 1103515245 + 12345;
            seq[k] = SW'(int'((lcg >> 16) & 63) - 32);
        end
        for (int j = 0; j < SYM; j++) begin
            lcg = lcg * 1103515245 + 12345;
            b[j] = int'((lcg >> 16) & 32767) % (2 * amp + 1) - amp;
        end
        for (int j = 0; j < SYM; j++) seq[dly + CP + j] = SW'(b[j]);
        for (int i = 0; i < CP; i++)  seq[dly + i] = SW'(b[SYM - CP + i]);
    endtask

    task automatic fill_const(input int v);
        for (int k = 0; k < TOTAL; k++) seq[k] = SW'(v);
    endtask

    task automatic run_search(input int gap, input bit junk, input string tag);
        bit stray = 1'b0;
        logic [OW-1:0] held;
        for (int k = 0; k < TOTAL; k++) begin
            @(negedge clk);
            if (done) stray = 1'b1;
            vld = 1'b1;
            smp = seq[k];
            if (gap > 0 && (k % 3) == 1 && k != TOTAL - 1) begin
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    if (done) stray = 1'b1;
                    vld = 1'b0;
                    smp = 12'sh5A5;
                end
            end
        end
        @(negedge clk);
        chk({tag, " R5 done after last sample"}, longint'(done), 1);
        chk({tag, " R5 R1 no early done"}, longint'(stray), 0);
        chk({tag, " R2 R3 offset"}, longint'(off), longint'(exp_d));
        chk({tag, " R4 peak"}, longint'(pk), exp_m);
        held = off;
        vld = junk;
        smp = 12'sh7FF;
        @(negedge clk);
        vld = 1'b0;
        chk({tag, " R5 single cycle"}, longint'(done), 0);
        repeat (3) @(negedge clk);
        chk({tag, " R6 result held"}, longint'(off), longint'(held));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 reset done", longint'(done), 0);
        chk("R9 reset offset", longint'(off), 0);
        chk("R9 reset peak", longint'(pk), 0);
        rst_n = 1'b1;

        // table walk; R7 via gaps, R8 via junk sample before the next vector
        for (int v = 0; v < NVEC; v++) begin
            build(VEC[v][0], VEC[v][1], VEC[v][2]);
            ref_model();
            run_search(VEC[v][3], VEC[v][4] != 0, $sformatf("vec%0d", v));
        end

        // R3: all zero input, tie everywhere
        fill_const(0);
        ref_model();
        run_search(0, 1'b0, "zero R3");
        chk("R3 zero input offset", longint'(off), 0);

        // R4: full-scale negative, no overflow
        fill_const(-2048);
        ref_model();
        run_search(1, 1'b0, "fullscale R4");
        chk("R4 full-scale peak", longint'(pk), 64'sd33554432);

        // R3: plateau of equal metrics across D=3..10
        fill_const(0);
        seq[10] = 12'sd100;
        seq[26] = 12'sd100;
        ref_model();
        run_search(0, 1'b0, "plateau R3");
        chk("R3 earliest of ties", longint'(off), 3);

        // R9: reset in mid-search
        build(7, 1200, 91);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            vld = 1'b1;
            smp = 12'sh3C3;
        end
        @(negedge clk);
        vld = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R9 mid-search reset offset", longint'(off), 0);
        chk("R9 mid-search reset peak", longint'(pk), 0);
        chk("R9 mid-search reset done", longint'(done), 0);
        rst_n = 1'b1;
        ref_model();
        run_search(0, 1'b0, "after reset R9");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule